// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter with Double Buffer

This block sends parallel words out on a single data line, one bit per cycle of a shift clock that an outside master supplies on an input pin. The block produces no clock of its own. Software writes a word into a holding register. When the shift register is idle the word moves straight into it and starts going out. A word written while another is still shifting waits in the holding register and is handed over the moment the last bit of the current word has been shifted out.

Data leaves least-significant bit first. After each falling edge of the external clock the line moves to the next bit, so the master can sample it on the rising edge. The external clock is brought into the system-clock domain through a flop synchroniser followed by a falling-edge detector. Words are 8 bits long by default. A 9-bit frame can be chosen at write time, and the extra bit is captured from a separate input together with the byte. A holding-empty flag, a shift-idle flag and a level interrupt request report the buffer state. The interrupt request is formed without any register stage, so it stays valid while the system clock is stopped.

Transmission runs only when the port is configured as a synchronous slave transmitter. That means synchronous mode and the port enable are set, internal clock sourcing is off, the transmit enable is set, and both receive enables are off.

Top module: `sst_tx_top`

## Requirements
- R1: After reset `hold_empty` is 1, `shift_empty` is 1, `ser_dout` is 1, and `irq` is 0 while `irq_en` is 0.
- R2: Transmission is enabled only when `mode_sync`=1, `port_en`=1, `clk_master`=0, `tx_en`=1, `rx_single`=0 and `rx_cont`=0. Under any other setting a written word stays in the holding register (`hold_empty`=0, `shift_empty`=1), and the shifter is cleared at the next clock edge.
- R3: When transmission is enabled, the holding register is full and the shifter is idle, the word enters the shifter at the next clock edge. After that edge `hold_empty`=1, `shift_empty`=0 and `ser_dout` equals bit 0 of the word.
- R4: Bits leave least-significant bit first. The line advances by one bit only after a synchronised falling edge of `ser_clk`, so each bit is stable at the next rising edge of `ser_clk`.
- R5: A word written while another is shifting keeps `hold_empty` at 0 until the falling edge that ends the current word. At that edge the waiting word is loaded, `hold_empty` rises and `shift_empty` stays 0.
- R6: `frame9`=1 at the write selects a 9-bit frame. The ninth bit sent is the value of `bit9` sampled in the same write cycle. With `frame9`=0 the frame is 8 bits.
- R7: `irq` equals `hold_empty` AND `irq_en` and has no register stage in its path.
- R8: `shift_empty` is 1 whenever no word is being shifted, and `ser_dout` is then 1. After the falling edge that ends the last word, with the holding register empty, `shift_empty` returns to 1.
- R9: A write clears `hold_empty` at the next clock edge. A second write into a full holding register replaces the waiting word, and only the newest word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Shift clock from the external master |
| mode_sync | input | 1 | Synchronous mode select |
| port_en | input | 1 | Serial port enable |
| clk_master | input | 1 | Internal clock sourcing; must be 0 for slave transmit |
| tx_en | input | 1 | Transmit enable |
| rx_single | input | 1 | Single-word receive enable; must be 0 |
| rx_cont | input | 1 | Continuous receive enable; must be 0 |
| frame9 | input | 1 | 9-bit frame select, sampled at write |
| bit9 | input | 1 | Ninth data bit, sampled at write |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data byte to transmit |
| irq_en | input | 1 | Transmit interrupt enable |
| ser_dout | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register idle status |
| irq | output | 1 | Transmit interrupt request |

## Verification
The hardest case to reach is the handoff between the two buffer stages. The second word has to be waiting at exactly the falling edge that retires the first, and the empty flag must stay low through every earlier edge. The bench gets there by writing the first word shortly after a falling edge of the free-running shift clock and the second a cycle later. It then counts falling edges and checks the flag after the seventh and again after the eighth. The inactive configurations are reached by writing while one enable condition is wrong. Two writes in that state check that the second word replaces the first. The port is then re-enabled in a low phase of the shift clock, and the serial monitor confirms that only the newest word appears.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int SST_DATA_W = 8;
    localparam int SST_CNT_W  = $clog2(SST_DATA_W + 1) + 1;

    typedef logic [SST_CNT_W-1:0] sst_cnt_t;

    typedef struct packed {
        logic                  nine;
        logic [SST_DATA_W:0]   bits;
    } sst_word_t;

    function automatic sst_cnt_t sst_last_index(input logic nine);
        return nine ? sst_cnt_t'(SST_DATA_W) : sst_cnt_t'(SST_DATA_W - 1);
    endfunction

    function automatic logic sst_slave_tx_ok(
        input logic sync_m, input logic pen, input logic clk_m,
        input logic txe, input logic rxs, input logic rxc);
        return sync_m & pen & ~clk_m & txe & ~rxs & ~rxc;
    endfunction

endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end

    assign fall_pulse = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
endmodule

// File: rtl/sst_hold_buf.sv
module sst_hold_buf
    import sst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  sst_word_t wr_word,
    input  logic      take,
    output logic      full,
    output sst_word_t word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            word <= wr_word;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      fall,
    input  logic      hold_full,
    input  sst_word_t hold_word,
    output logic      take,
    output logic      busy,
    output logic      dout
);
    logic [SST_DATA_W:0] sh_q;
    sst_cnt_t            cnt_q;
    logic                nine_q;
    logic                at_last;

    assign at_last = (cnt_q == sst_last_index(nine_q));
    assign take    = active & hold_full & (~busy | (fall & at_last));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sh_q   <= '0;
            cnt_q  <= '0;
            nine_q <= 1'b0;
        end else if (!active) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
        end else if (take) begin
            busy   <= 1'b1;
            sh_q   <= hold_word.bits;
            nine_q <= hold_word.nine;
            cnt_q  <= '0;
        end else if (busy && fall) begin
            if (at_last) begin
                busy <= 1'b0;
            end else begin
                sh_q  <= {1'b0, sh_q[SST_DATA_W:1]};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dout = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sst_tx_top.sv
module sst_tx_top
    import sst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ser_clk,
    input  logic                  mode_sync,
    input  logic                  port_en,
    input  logic                  clk_master,
    input  logic                  tx_en,
    input  logic                  rx_single,
    input  logic                  rx_cont,
    input  logic                  frame9,
    input  logic                  bit9,
    input  logic                  wr_en,
    input  logic [SST_DATA_W-1:0] wr_data,
    input  logic                  irq_en,
    output logic                  ser_dout,
    output logic                  hold_empty,
    output logic                  shift_empty,
    output logic                  irq
);
    logic      fall_pulse;
    logic      xmit_ok;
    logic      take;
    logic      full;
    logic      busy;
    sst_word_t new_word;
    sst_word_t held_word;

    assign xmit_ok       = sst_slave_tx_ok(mode_sync, port_en, clk_master,
                                           tx_en, rx_single, rx_cont);
    assign new_word.nine = frame9;
    assign new_word.bits = {frame9 & bit9, wr_data};

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (ser_clk),
        .fall_pulse (fall_pulse)
    );

    sst_hold_buf u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (new_word),
        .take    (take),
        .full    (full),
        .word    (held_word)
    );

    sst_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (xmit_ok),
        .fall      (fall_pulse),
        .hold_full (full),
        .hold_word (held_word),
        .take      (take),
        .busy      (busy),
        .dout      (ser_dout)
    );

    assign hold_empty  = ~full;
    assign shift_empty = ~busy;
    assign irq         = hold_empty & irq_en;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic tx_en,
    input logic irq_en,
    input logic irq,
    input logic hold_empty,
    input logic shift_empty,
    input logic ser_dout,
    input logic fall_seen,
    input logic xmit_ok
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !hold_empty); // R9

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> shift_empty); // R2

    AST_LOAD_FRESH: assert property (@(posedge clk) disable iff (rst)
        ($fell(shift_empty) && !$past(wr_en)) |-> $rose(hold_empty)); // R3

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fall_seen && !shift_empty && xmit_ok) |=> $stable(ser_dout)); // R4

    AST_WAIT_FULL: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && !shift_empty && !fall_seen) |=> !hold_empty); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R7

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> ser_dout); // R8
endmodule

bind sst_tx_top sst_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .tx_en       (tx_en),
    .irq_en      (irq_en),
    .irq         (irq),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .ser_dout    (ser_dout),
    .fall_seen   (fall_pulse),
    .xmit_ok     (xmit_ok)
);

// File: tb/sst_tx_top_bench.sv
module sst_tx_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b1;
    logic       mode_sync = 1'b1, port_en = 1'b1, clk_master = 1'b0;
    logic       tx_en = 1'b1, rx_single = 1'b0, rx_cont = 1'b0;
    logic       frame9 = 1'b0, bit9 = 1'b0, wr_en = 1'b0, irq_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ser_dout, hold_empty, shift_empty, irq;

    int  n_cmp = 0;
    int  n_mis = 0;
    bit  finished = 0;
    logic exp_q[$];

    sst_tx_top u_sst_tx_top (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .mode_sync(mode_sync),
        .port_en(port_en), .clk_master(clk_master), .tx_en(tx_en),
        .rx_single(rx_single), .rx_cont(rx_cont), .frame9(frame9),
        .bit9(bit9), .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .ser_dout(ser_dout), .hold_empty(hold_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    always #10ns clk = ~clk;
    always #200ns ser_clk = ~ser_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected bit per rising shift-clock edge while shifting
    always @(posedge ser_clk) begin
        #1ns;
        if (!rst && shift_empty === 1'b0) begin
            if (exp_q.size() == 0) chk("R4 unexpected serial bit", 1, 0);
            else chk("R4/R6 serial bit order", ser_dout, exp_q.pop_front());
        end
    end

    task automatic put_word(input logic [7:0] d, input logic nine, input logic b9,
                            input bit align, input bit track);
        if (align) begin
            @(negedge ser_clk);
            repeat (4) @(negedge clk);
        end
        wr_data = d; frame9 = nine; bit9 = b9; wr_en = 1'b1;
        if (track) begin
            for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
            if (nine) exp_q.push_back(b9);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 holding full after write", hold_empty, 0);
    endtask

    task automatic after_falls(input int n);
        for (int i = 0; i < n; i++) @(negedge ser_clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    initial begin
        #3ms;
        n_cmp++; n_mis++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 shift_empty", shift_empty, 1);
        chk("R1 ser_dout", ser_dout, 1);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R7 interrupt follows empty flag
        irq_en = 1'b1; #1ns;
        chk("R7 irq with empty", irq, 1);

        // R3 single word loads directly
        put_word(8'h3C, 1'b0, 1'b0, 1, 1);
        chk("R7 irq low while full", irq, 0);
        @(negedge clk);
        chk("R3 hold_empty after load", hold_empty, 1);
        chk("R3 shift_empty after load", shift_empty, 0);
        chk("R3 first bit on line", ser_dout, 0);
        chk("R7 irq after load", irq, 1);
        after_falls(8);
        chk("R8 idle after word", shift_empty, 1);
        chk("R8 idle line high", ser_dout, 1);

        // R5 back-to-back handoff
        put_word(8'hA6, 1'b0, 1'b0, 1, 1);
        put_word(8'h59, 1'b0, 1'b0, 0, 1);
        chk("R5 second word waits", hold_empty, 0);
        after_falls(7);
        chk("R5 still full before last edge", hold_empty, 0);
        after_falls(1);
        chk("R5 empty after handoff", hold_empty, 1);
        chk("R5 shifter stays busy", shift_empty, 0);
        after_falls(8);
        chk("R8 idle after pair", shift_empty, 1);

        // R6 nine-bit frames
        put_word(8'h5A, 1'b1, 1'b1, 1, 1);
        put_word(8'h81, 1'b1, 1'b0, 0, 1);
        after_falls(9);
        chk("R6 nine-bit handoff", hold_empty, 1);
        after_falls(9);
        chk("R6 idle after nine-bit pair", shift_empty, 1);

        // R2 disabled configurations hold the word; R9 overwrite
        tx_en = 1'b0;
        put_word(8'hFF, 1'b0, 1'b0, 1, 0);
        put_word(8'h96, 1'b0, 1'b0, 0, 1);
        after_falls(2);
        chk("R2 tx_en low holds", hold_empty, 0);
        chk("R2 tx_en low idle", shift_empty, 1);
        tx_en = 1'b1; rx_cont = 1'b1;
        after_falls(2);
        chk("R2 rx_cont blocks", shift_empty, 1);
        rx_cont = 1'b0; clk_master = 1'b1;
        after_falls(1);
        chk("R2 clk_master blocks", shift_empty, 1);
        clk_master = 1'b0; rx_single = 1'b1;
        after_falls(1);
        chk("R2 rx_single blocks", shift_empty, 1);
        rx_single = 1'b0; port_en = 1'b0;
        after_falls(1);
        chk("R2 port_en blocks", hold_empty, 0);
        @(negedge ser_clk);
        repeat (4) @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
        chk("R2 enable loads held word", shift_empty, 0);
        chk("R9 newest word first bit", ser_dout, 0);
        after_falls(8);
        chk("R8 idle at end", shift_empty, 1);
        chk("R9 only newest sent", exp_q.size(), 0);
        summary();
    end
endmodule